// File: doc/BRIEF.md
# Twisted-Ring Decade Counter

This block divides a stream of count events by ten. Its state lives in a five-stage twisted-ring (Johnson) shift register. The register walks through ten legal codes, and a bank of two-input gates turns each code into one of ten one-hot state lines. An active-low carry is low for the upper half of the count. It can feed the rising-edge count input of a following counter to build longer dividers.

Two count inputs control the count, and each one gates the other. The first advances the counter on its rising edge while the second is low. The second advances it on its falling edge while the first is high. Both inputs pass through synchronizers into the system clock domain, and edge detection runs on the synchronized copies. An asynchronous clear returns the counter to state zero and overrides everything else. A parallel load port for test lets any of the 32 register patterns be injected. Feedback into the middle stage is modified so that any corrupted pattern falls back into the legal cycle.

Top module: `twisted_ring_decade`

## Requirements
- R1: After the synchronous reset `rst`, the counter is in state 0: `dec_o` equals 1 (only bit 0 high) and `carry_n_o` is 1.
- R2: A rising edge on `cp_up_i` while `cp_dn_i` is low advances the state by one. The new state is visible after the third rising clock edge that follows the input change.
- R3: A falling edge on `cp_dn_i` while `cp_up_i` is high advances the state by one, with the same latency as R2.
- R4: The count inputs have no effect in these cases: `cp_up_i` rises while `cp_dn_i` is high, `cp_dn_i` falls while `cp_up_i` is low, `cp_up_i` falls, or `cp_dn_i` rises.
- R5: The counter passes through exactly ten states in order, and state 9 wraps to state 0. Ring bit 0 is the first stage. For k from 0 to 5, state k holds the low k bits set. For k from 6 to 9, state k holds 11111 with the low k-5 bits cleared.
- R6: `carry_n_o` is high in states 0 to 4 and low in states 5 to 9.
- R7: `dec_o[k]` is high exactly when the counter is in legal state k, so a legal state shows exactly one high bit.
- R8: While `clr_i` is high, the state is 0 without waiting for a clock edge. Count edges that occur during the clear are ignored.
- R9: When `ld_en_i` is high at a clock edge, the ring takes `ld_val_i` and any advance due at that edge is dropped. `clr_i` overrides the load.
- R10: From any of the 22 illegal ring patterns, the counter is in a legal state after at most 11 advances, and from then on it follows the normal cycle.
- R11: If a rising edge on `cp_up_i` and a falling edge on `cp_dn_i` meet their conditions in the same clock cycle, the counter advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_up_i | input | 1 | Rising-edge count input, gated by `cp_dn_i` low |
| cp_dn_i | input | 1 | Falling-edge count input, gated by `cp_up_i` high |
| clr_i | input | 1 | Asynchronous clear to state 0, highest priority |
| ld_en_i | input | 1 | Test load enable |
| ld_val_i | input | STAGES | Ring pattern to load |
| dec_o | output | 2*STAGES | One-hot decoded state lines |
| carry_n_o | output | 1 | Active-low carry, low in states 5 to 9 |

## Verification
The bench loads every one of the 22 illegal patterns and advances each one eleven times. It then follows ten more advances to confirm the normal sequence. A design with a wrong feedback term would stay trapped in a parasitic loop, or would corrupt a legal code. Random input pairs exercise the cross-gating: a design that ignores the gate counts on blocked edges, and one that ORs the two conditions without merging them advances twice when both edges land together. Clear pulses with count activity inside them catch a clear that waits for a clock edge or that lets stale edges leak out afterwards. Loads issued in the cycle of a pending advance catch a reversed priority.

// File: rtl/tr_decade_pkg.sv
package tr_decade_pkg;

  typedef struct packed {
    logic up_rise;
    logic dn_fall;
  } tr_edges_t;

  // Legal code of state k in an n-stage twisted ring (bit 0 = first stage)
  function automatic logic [31:0] tr_code(input int k, input int n);
    logic [31:0] full;
    full = (32'd1 << n) - 32'd1;
    if (k <= n) return (32'd1 << k) - 32'd1;
    return full & ~((32'd1 << (k - n)) - 32'd1);
  endfunction

  function automatic logic tr_is_legal(input logic [31:0] v, input int n);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < 2 * n; k++)
      if (v == tr_code(k, n)) hit = 1'b1;
    return hit;
  endfunction

endpackage

// File: rtl/tr_edge_sync.sv
module tr_edge_sync
  import tr_decade_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cp_up,
  input  logic cp_dn,
  output logic adv
);
  logic [SYNC_STAGES-1:0] up_sh, dn_sh;
  logic up_p, dn_p;
  logic up_s, dn_s;
  tr_edges_t ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_sh <= '0;
      dn_sh <= '0;
      up_p  <= 1'b0;
      dn_p  <= 1'b0;
    end else begin
      up_sh <= {up_sh[SYNC_STAGES-2:0], cp_up};
      dn_sh <= {dn_sh[SYNC_STAGES-2:0], cp_dn};
      up_p  <= up_sh[SYNC_STAGES-1];
      dn_p  <= dn_sh[SYNC_STAGES-1];
    end
  end

  assign up_s = up_sh[SYNC_STAGES-1];
  assign dn_s = dn_sh[SYNC_STAGES-1];

  // Each input gates the other; a coincident pair merges into one advance
  assign ev.up_rise = up_s & ~up_p & ~dn_s;
  assign ev.dn_fall = ~dn_s & dn_p & up_s;
  assign adv = ev.up_rise | ev.dn_fall;

  // R11: no two advances in consecutive cycles, so a coincident pair is one step
  p_single_step_r11: assert property (@(posedge clk) disable iff (rst)
    adv |=> !adv);

  // R4: a blocked rising edge (other input high) never advances
  p_gate_up_r4: assert property (@(posedge clk) disable iff (rst)
    (up_s && !up_p && dn_s && dn_p) |-> !adv);

endmodule

// File: rtl/tr_ring_core.sv
module tr_ring_core
  import tr_decade_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ld_en,
  input  logic [STAGES-1:0] ld_val,
  input  logic              adv,
  output logic [STAGES-1:0] ring
);
  localparam int FIX_IDX = STAGES / 2;
  localparam int RUN_MAX = 2 * STAGES + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic [STAGES-1:0] nxt;
  logic              legal;
  logic [RUN_W-1:0]  illegal_run;

  for (genvar i = 0; i < STAGES; i++) begin : g_fb
    if (i == 0) begin : g_head
      assign nxt[i] = ~ring[STAGES-1];
    end else if (i == FIX_IDX) begin : g_fix
      // Blocks the x0 1 0 sub-pattern that would close an illegal loop
      assign nxt[i] = ring[i-1] & (ring[0] | ring[i]);
    end else begin : g_shift
      assign nxt[i] = ring[i-1];
    end
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr)        ring <= '0;
    else if (rst)   ring <= '0;
    else if (ld_en) ring <= ld_val;
    else if (adv)   ring <= nxt;
  end

  assign legal = tr_is_legal({{(32-STAGES){1'b0}}, ring}, STAGES);

  // Advances spent in illegal codes since the last legal one
  always_ff @(posedge clk or posedge clr) begin
    if (clr)                   illegal_run <= '0;
    else if (rst || ld_en)     illegal_run <= '0;
    else if (legal)            illegal_run <= '0;
    else if (adv && illegal_run != RUN_W'(RUN_MAX))
                               illegal_run <= illegal_run + 1'b1;
  end

  // R10: at most ten advances may leave the ring still illegal
  p_recover_r10: assert property (@(posedge clk) disable iff (rst || clr)
    !legal |-> illegal_run <= RUN_W'(10));

  // R5: a legal code steps to a different legal code
  p_legal_step_r5: assert property (@(posedge clk) disable iff (rst || clr)
    (adv && !ld_en && legal) |=> (legal && ring != $past(ring)));

  // R4: without advance, load or clear the ring holds
  p_hold_r4: assert property (@(posedge clk) disable iff (rst || clr)
    (!adv && !ld_en) |=> $stable(ring));

  // R8: a clear held over an edge leaves the ring at zero
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr && $past(clr)) |-> ring == '0);

  // R9: a load lands at the next edge
  p_load_r9: assert property (@(posedge clk) disable iff (rst || clr)
    ld_en |=> ring == $past(ld_val));

endmodule

// File: rtl/tr_decode.sv
module tr_decode #(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0]   ring,
  output logic [2*STAGES-1:0] dec,
  output logic                carry_n
);
  localparam int NSTATES = 2 * STAGES;

  for (genvar k = 0; k < NSTATES; k++) begin : g_term
    if (k == 0) begin : g_zero
      assign dec[k] = ~ring[0] & ~ring[STAGES-1];
    end else if (k < STAGES) begin : g_fill
      assign dec[k] = ring[k-1] & ~ring[k];
    end else if (k == STAGES) begin : g_full
      assign dec[k] = ring[STAGES-1] & ring[0];
    end else begin : g_drain
      assign dec[k] = ~ring[k-STAGES-1] & ring[k-STAGES];
    end
  end

  assign carry_n = ~ring[STAGES-1];

endmodule

// File: rtl/twisted_ring_decade.sv
module twisted_ring_decade
  import tr_decade_pkg::*;
#(
  parameter int STAGES      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cp_up_i,
  input  logic                cp_dn_i,
  input  logic                clr_i,
  input  logic                ld_en_i,
  input  logic [STAGES-1:0]   ld_val_i,
  output logic [2*STAGES-1:0] dec_o,
  output logic                carry_n_o
);
  logic              adv;
  logic [STAGES-1:0] ring;

  tr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .cp_up (cp_up_i),
    .cp_dn (cp_dn_i),
    .adv   (adv)
  );

  tr_ring_core #(.STAGES(STAGES)) u_core (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_i),
    .ld_en  (ld_en_i),
    .ld_val (ld_val_i),
    .adv    (adv),
    .ring   (ring)
  );

  tr_decode #(.STAGES(STAGES)) u_dec (
    .ring    (ring),
    .dec     (dec_o),
    .carry_n (carry_n_o)
  );

  // R7: every legal code shows exactly one decoded line
  p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    tr_is_legal({{(32-STAGES){1'b0}}, ring}, STAGES) |-> $onehot(dec_o));

  // R6: carry falls only when leaving state 4 by an advance
  p_carry_r6: assert property (@(posedge clk) disable iff (rst || clr_i)
    ($fell(carry_n_o) && $past(!ld_en_i) && $past(!clr_i)) |-> $past(dec_o[STAGES-1]));

endmodule

// File: tb/twisted_ring_decade_tb_top.sv
`timescale 1ns/1ps
module twisted_ring_decade_tb_top;
  localparam int N = 5;
  localparam int D = 2 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cp_up = 1'b0, cp_dn = 1'b0, clr = 1'b0, ld_en = 1'b0;
  logic [N-1:0] ld_val = '0;
  logic [D-1:0] dec;
  logic carry_n;

  int n_chk = 0, n_bad = 0;
  int exp_k = 0;

  always #5 clk = ~clk;

  twisted_ring_decade #(.STAGES(N), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .cp_up_i(cp_up), .cp_dn_i(cp_dn), .clr_i(clr),
    .ld_en_i(ld_en), .ld_val_i(ld_val), .dec_o(dec), .carry_n_o(carry_n)
  );

  function automatic logic [N-1:0] code_of(input int k);
    if (k <= N) return N'((1 << k) - 1);
    return N'(((1 << N) - 1) & ~((1 << (k - N)) - 1));
  endfunction

  function automatic bit legal_code(input logic [N-1:0] v);
    for (int k = 0; k < D; k++) if (v == code_of(k)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int hot_index(input logic [D-1:0] v);
    if ($countones(v) != 1) return -1;
    for (int k = 0; k < D; k++) if (v[k]) return k;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic check_state(input int k, input string tag);
    chk(dec == D'(1 << k), {tag, " decode"}, int'(dec), 1 << k);
    chk(carry_n == (k < 5), {tag, " carry"}, int'(carry_n), int'(k < 5));
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_in(input logic u, input logic d);
    cp_up = u;
    cp_dn = d;
    wait_n(4);
  endtask

  task automatic step_up();
    set_in(1'b1, 1'b0);
    set_in(1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    check_state(0, "R1 reset");

    // R2: rising cp_up with cp_dn low
    set_in(1'b1, 1'b0);
    check_state(1, "R2 up rise");
    // R4: cp_up falling has no effect
    set_in(1'b0, 1'b0);
    check_state(1, "R4 up fall");
    // R4: cp_dn rising has no effect
    set_in(1'b0, 1'b1);
    check_state(1, "R4 dn rise");
    // R4: cp_up rising while cp_dn high is blocked
    set_in(1'b1, 1'b1);
    check_state(1, "R4 up blocked");
    // R3: cp_dn falling while cp_up high
    set_in(1'b1, 1'b0);
    check_state(2, "R3 dn fall");
    // R4: cp_dn falling while cp_up low is blocked
    set_in(1'b0, 1'b0);
    set_in(1'b0, 1'b1);
    set_in(1'b0, 1'b0);
    check_state(2, "R4 dn blocked");
    // R11: both conditions in one cycle
    set_in(1'b0, 1'b1);
    set_in(1'b1, 1'b0);
    check_state(3, "R11 coincident");
    set_in(1'b0, 1'b0);
    exp_k = 3;

    // R5 / R6 / R7: full lap with wrap
    for (int i = 0; i < D; i++) begin
      step_up();
      exp_k = (exp_k + 1) % D;
      check_state(exp_k, "R5 lap");
    end

    // R9: load a legal code
    @(negedge clk);
    ld_val = code_of(7); ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
    check_state(7, "R9 load");
    // R9: load wins over an advance due at the same edge
    cp_up = 1'b1;
    wait_n(2);
    ld_val = code_of(2); ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
    wait_n(3);
    check_state(2, "R9 load over advance");
    set_in(1'b0, 1'b0);
    check_state(2, "R9 no late advance");
    // R9 / R8: clear overrides load
    @(negedge clk);
    ld_val = code_of(6); ld_en = 1'b1; clr = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
    check_state(0, "R8 clear over load");
    @(negedge clk);
    clr = 1'b0;
    wait_n(2);
    check_state(0, "R8 after release");
    exp_k = 0;

    // R8: asynchronous clear, edges during clear ignored
    step_up(); step_up();
    exp_k = 2;
    check_state(2, "R2 before clear");
    @(negedge clk);
    clr = 1'b1;
    #1;
    check_state(0, "R8 async");
    @(negedge clk);
    step_up(); step_up();
    check_state(0, "R8 hold");
    clr = 1'b0;
    wait_n(4);
    check_state(0, "R8 no leak");
    exp_k = 0;

    // R10: recovery from every illegal pattern
    for (int v = 0; v < (1 << N); v++) begin
      if (!legal_code(N'(v))) begin
        bit ok;
        int k0;
        @(negedge clk);
        ld_val = N'(v); ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
        for (int s = 0; s < 11; s++) step_up();
        k0 = hot_index(dec);
        ok = (k0 >= 0) && (carry_n == (k0 < 5));
        for (int s = 1; s <= D && ok; s++) begin
          step_up();
          if (dec != D'(1 << ((k0 + s) % D))) ok = 1'b0;
          if (carry_n != (((k0 + s) % D) < 5)) ok = 1'b0;
        end
        chk(ok, "R10 recovery", v, 1);
        if (k0 >= 0) exp_k = k0;
      end
    end

    // Random input pairs mixed with clears (R2 R3 R4 R11 R8)
    @(negedge clk);
    ld_val = code_of(0); ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
    exp_k = 0;
    for (int it = 0; it < 400; it++) begin
      logic pu, pd, u, d;
      bit a_up, a_dn;
      pu = cp_up; pd = cp_dn;
      if ($urandom % 16 == 0) begin
        @(negedge clk);
        clr = 1'b1;
        #1;
        check_state(0, "R8 random clear");
        @(negedge clk);
        set_in(1'($urandom), 1'($urandom));
        clr = 1'b0;
        wait_n(4);
        check_state(0, "R8 random release");
        exp_k = 0;
      end else begin
        u = 1'($urandom); d = 1'($urandom);
        a_up = u && !pu && !d;
        a_dn = !d && pd && u;
        set_in(u, d);
        if (a_up || a_dn) exp_k = (exp_k + 1) % D;
        if (a_up && a_dn) check_state(exp_k, "R11 random");
        else if (a_up)    check_state(exp_k, "R2 random");
        else if (a_dn)    check_state(exp_k, "R3 random");
        else              check_state(exp_k, "R4 random");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule